// File: doc/BRIEF.md
# Layered Strip Hit Recorder with Trigger-Matched Serial Readout

The block watches 32 discriminated strip signals, organised as four layers of eight strips, on a 40 MHz clock. Every clock cycle in which at least one strip is active becomes one hit word. That word joins the strip pattern to the value of a free-running coarse time counter, and it goes into a circular buffer that overwrites its oldest word when full. In the same cycle, a layer-coincidence stage counts how many layers have any strip active. If the count reaches a programmable majority, the stage pulses a local trigger toward a central trigger unit.

The central unit later returns a main trigger carrying a time stamp. The block then walks the whole buffer from oldest to newest and copies every word whose tag lies within ±W counts of the stamp into a small readout store. It sends those words out on one serial line as a framed bit string. While a readout is in progress the block reports busy. A main trigger that arrives during that time is discarded and counted. Recording of new hits never pauses.

Top module: `hit_match_capture`

## Requirements
- R1: While reset is low and in the first cycle after it, `ltrig_out`, `ser_out` and `busy` are 0 and `drop_count` is 0.
- R2: Layer L is strips `hit_in[8L+7:8L]`. A pattern held on `hit_in` for one cycle drives `ltrig_out` high for exactly one cycle, three rising edges after the edge that sampled it, when the number of layers with any strip active is at least the threshold.
- R3: The threshold equals `majority_cfg` for settings 2, 3 and 4. Settings 0 and 1 act as 2, and settings above 4 act as 4.
- R4: A nonzero pattern sampled at rising edge n is stored once, as the word {tag, pattern}, where n counts edges from the first edge with `rst_n` high. The tag is (n+1) mod 2^TAG_W, sits above the pattern, and is TAG_W bits wide. An all-zero pattern is not stored.
- R5: A main trigger selects every retained word whose tag differs from `mtrig_stamp` by at most `win_cfg` in modular distance, in either direction. Distance is measured across the counter wrap.
- R6: Only the last 2^DEPTH_LOG2 stored words are retained. Selected words are sent oldest first.
- R7: With no frame in progress, `ser_out` is 0. A frame is a 1 start bit, then the CNT_W-bit word count MSB first, then each selected word MSB first, then one bit that makes the count bits plus word bits plus this bit hold an even number of ones.
- R8: At most SNAP_DEPTH words are sent per trigger. These are the oldest matching ones, and the count field reports the number sent.
- R9: `mtrig_valid` while `busy` is 0 starts a readout, and `busy` is high from the next cycle until the parity bit is driven. `mtrig_valid` while `busy` is high starts nothing and adds 1 to `drop_count`, which saturates at all ones.
- R10: Patterns arriving during a readout are still stored. They are absent from the frame in progress, because it reflects the buffer at the accept edge, and a later trigger can read them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_in | input | LAYERS*STRIPS | Asynchronous discriminated strip signals, layer-major |
| majority_cfg | input | $clog2(LAYERS+1) | Layer coincidence threshold |
| win_cfg | input | TAG_W | Half-width W of the match window, in tag counts |
| mtrig_valid | input | 1 | One-cycle main trigger request |
| mtrig_stamp | input | TAG_W | Time stamp carried by the main trigger |
| ltrig_out | output | 1 | Local layer-coincidence trigger pulse |
| ser_out | output | 1 | Framed serial readout line |
| busy | output | 1 | Readout in progress |
| drop_count | output | CNT_W | Number of main triggers discarded while busy |

## Verification
The hardest situations to reach from the ports are those that depend on buffer history. One is a word that has just been overwritten by ring wrap. Another is a tag that straddles the counter wrap. A third is a hit that lands while a scan is still walking the buffer. The bench keeps its own list of every nonzero pattern it presented, each with the tag derived from its own edge count. It reaches ring wrap by writing a burst longer than the buffer. It reaches the counter wrap by waiting until the next tag will be the largest value, then placing two consecutive hits across it. To reach the mid-scan case, it injects hits and a second trigger in the first cycles after an accept. It then fires a further trigger aimed at those hits.

// File: rtl/hmc_pkg.sv
// Shared types for the strip hit recorder.
// Assumes: nothing beyond standard SystemVerilog.
package hmc_pkg;

    // Readout sequencer phases
    typedef enum logic [2:0] {
        RD_IDLE,
        RD_SCAN,
        RD_HEAD,
        RD_DATA,
        RD_PAR
    } rd_phase_t;

endpackage

// File: rtl/hmc_hit_sync.sv
// Two-flop synchroniser on every strip input, followed by the layer
// coincidence counter that produces the local trigger.
// Assumes: strip pulses last at least one clock; threshold input is quasi-static.
module hmc_hit_sync #(
    parameter int LAYERS = 4,
    parameter int STRIPS = 8,
    localparam int N_CH  = LAYERS * STRIPS,
    localparam int CFG_W = $clog2(LAYERS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   hit_in,
    input  logic [CFG_W-1:0]  majority_cfg,
    output logic [N_CH-1:0]   pattern,
    output logic              ltrig
);

    logic [N_CH-1:0]   meta_q;
    logic [LAYERS-1:0] layer_hit;
    logic [CFG_W-1:0]  n_layers;
    logic [CFG_W-1:0]  thr;

    // Purpose: bring asynchronous strip signals into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q  <= '0;
            pattern <= '0;
        end else begin
            meta_q  <= hit_in;
            pattern <= meta_q;
        end
    end

    // One OR per layer
    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        assign layer_hit[l] = |pattern[l*STRIPS +: STRIPS];
    end

    // Purpose: count layers that have at least one active strip
    always_comb begin
        n_layers = '0;
        for (int l = 0; l < LAYERS; l++) begin
            n_layers = n_layers + CFG_W'(layer_hit[l]);
        end
    end

    // Purpose: clamp the majority setting into the range 2..LAYERS
    always_comb begin
        if (majority_cfg < CFG_W'(2))
            thr = CFG_W'(2);
        else if (majority_cfg > CFG_W'(LAYERS))
            thr = CFG_W'(LAYERS);
        else
            thr = majority_cfg;
    end

    // Purpose: register the coincidence decision as the local trigger
    always_ff @(posedge clk) begin
        if (!rst_n) ltrig <= 1'b0;
        else        ltrig <= (n_layers >= thr);
    end

endmodule

// File: rtl/hmc_tag_ring.sv
// Free-running time tag plus circular store of {tag, pattern} words.
// A word is written in every cycle with a nonzero pattern; the oldest
// word is overwritten when full. Exposes next-cycle pointer and fill
// so a reader can freeze a consistent view at any edge.
// Assumes: one asynchronous read port is acceptable for the target store.
module hmc_tag_ring #(
    parameter int TAG_W      = 16,
    parameter int PAT_W      = 32,
    parameter int DEPTH_LOG2 = 8,
    localparam int WORD_W    = TAG_W + PAT_W,
    localparam int DEPTH     = 1 << DEPTH_LOG2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PAT_W-1:0]      pattern,
    input  logic [DEPTH_LOG2-1:0] rd_idx,
    output logic [WORD_W-1:0]     rd_word,
    output logic [DEPTH_LOG2-1:0] wr_ptr_nxt,
    output logic [DEPTH_LOG2:0]   fill_nxt
);

    localparam logic [DEPTH_LOG2:0] FULL = {1'b1, {DEPTH_LOG2{1'b0}}};

    logic [WORD_W-1:0]     mem [DEPTH];
    logic [TAG_W-1:0]      tag;
    logic [DEPTH_LOG2-1:0] wr_ptr;
    logic [DEPTH_LOG2:0]   fill;
    logic                  wr_en;

    assign wr_en      = |pattern;
    assign wr_ptr_nxt = wr_ptr + DEPTH_LOG2'(wr_en);
    assign fill_nxt   = (fill == FULL) ? fill : fill + (DEPTH_LOG2 + 1)'(wr_en);
    assign rd_word    = mem[rd_idx];

    // Purpose: advance time tag, write pointer and fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag    <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else begin
            tag    <= tag + TAG_W'(1);
            wr_ptr <= wr_ptr_nxt;
            fill   <= fill_nxt;
        end
    end

    // Purpose: store the tagged hit word
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= {tag, pattern};
    end

endmodule

// File: rtl/hmc_match_ser.sv
// Main-trigger matcher and serialiser. On accept it freezes the ring
// pointer and fill, walks every slot oldest first, copies words whose
// tag is within the window into a small store, then shifts out
// start bit, count, words and an even parity bit.
// Assumes: SNAP_DEPTH >= 2 and SNAP_DEPTH < 2**CNT_W; WORD_W > CNT_W + 1.
module hmc_match_ser
    import hmc_pkg::*;
#(
    parameter int TAG_W      = 16,
    parameter int PAT_W      = 32,
    parameter int DEPTH_LOG2 = 8,
    parameter int SNAP_DEPTH = 16,
    parameter int CNT_W      = 8,
    localparam int WORD_W    = TAG_W + PAT_W,
    localparam int SNAP_W    = $clog2(SNAP_DEPTH),
    localparam int BC_W      = $clog2(WORD_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mtrig_valid,
    input  logic [TAG_W-1:0]      mtrig_stamp,
    input  logic [TAG_W-1:0]      win_cfg,
    input  logic [DEPTH_LOG2-1:0] wr_ptr_nxt,
    input  logic [DEPTH_LOG2:0]   fill_nxt,
    input  logic [WORD_W-1:0]     rd_word,
    output logic [DEPTH_LOG2-1:0] rd_idx,
    output logic                  ser_out,
    output logic                  busy,
    output logic [CNT_W-1:0]      drop_count
);

    localparam logic [DEPTH_LOG2:0] FULL   = {1'b1, {DEPTH_LOG2{1'b0}}};
    localparam logic [CNT_W-1:0]    SNAP_V = CNT_W'(SNAP_DEPTH);

    rd_phase_t             phase;
    logic [DEPTH_LOG2-1:0] base, scan_k;
    logic [DEPTH_LOG2:0]   fill0;
    logic [TAG_W-1:0]      stamp, win;
    logic [CNT_W-1:0]      n_hit, n_hit_nxt, word_idx;
    logic [WORD_W-1:0]     snap [SNAP_DEPTH];
    logic [WORD_W-1:0]     out_sr;
    logic [BC_W-1:0]       bit_cnt;
    logic [SNAP_W-1:0]     next_slot;
    logic                  par, bit_now, slot_live, in_win, take;
    logic [TAG_W-1:0]      tag_rd, d_up, d_dn;

    assign busy      = (phase != RD_IDLE);
    assign rd_idx    = base + scan_k;
    assign tag_rd    = rd_word[WORD_W-1 -: TAG_W];
    assign d_up      = tag_rd - stamp;
    assign d_dn      = stamp - tag_rd;
    assign slot_live = ({1'b0, scan_k} >= (FULL - fill0));
    assign in_win    = (d_up <= win) || (d_dn <= win);
    assign take      = (phase == RD_SCAN) && slot_live && in_win && (n_hit < SNAP_V);
    assign n_hit_nxt = n_hit + CNT_W'(take);
    assign next_slot = word_idx[SNAP_W-1:0] + SNAP_W'(1);

    // Purpose: select the bit placed on the line at the next edge
    always_comb begin
        case (phase)
            RD_HEAD, RD_DATA: bit_now = out_sr[WORD_W-1];
            RD_PAR:           bit_now = par;
            default:          bit_now = 1'b0;
        endcase
    end

    // Purpose: copy matching words into the readout store
    always_ff @(posedge clk) begin
        if (take) snap[n_hit[SNAP_W-1:0]] <= rd_word;
    end

    // Purpose: readout sequencer, serial line and dropped-trigger count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= RD_IDLE;
            base       <= '0;
            scan_k     <= '0;
            fill0      <= '0;
            stamp      <= '0;
            win        <= '0;
            n_hit      <= '0;
            word_idx   <= '0;
            out_sr     <= '0;
            bit_cnt    <= '0;
            par        <= 1'b0;
            ser_out    <= 1'b0;
            drop_count <= '0;
        end else begin
            ser_out <= bit_now;
            if (mtrig_valid && busy && (drop_count != '1))
                drop_count <= drop_count + CNT_W'(1);
            case (phase)
                RD_IDLE: if (mtrig_valid) begin
                    base   <= wr_ptr_nxt;
                    fill0  <= fill_nxt;
                    stamp  <= mtrig_stamp;
                    win    <= win_cfg;
                    scan_k <= '0;
                    n_hit  <= '0;
                    par    <= 1'b0;
                    phase  <= RD_SCAN;
                end
                RD_SCAN: begin
                    n_hit  <= n_hit_nxt;
                    scan_k <= scan_k + DEPTH_LOG2'(1);
                    if (&scan_k) begin
                        out_sr  <= {1'b1, n_hit_nxt, {(WORD_W - CNT_W - 1){1'b0}}};
                        bit_cnt <= '0;
                        phase   <= RD_HEAD;
                    end
                end
                RD_HEAD: begin
                    out_sr  <= out_sr << 1;
                    bit_cnt <= bit_cnt + BC_W'(1);
                    if (bit_cnt != '0) par <= par ^ bit_now;
                    if (bit_cnt == BC_W'(CNT_W)) begin
                        bit_cnt  <= '0;
                        word_idx <= '0;
                        out_sr   <= snap[0];
                        phase    <= (n_hit == '0) ? RD_PAR : RD_DATA;
                    end
                end
                RD_DATA: begin
                    par     <= par ^ bit_now;
                    out_sr  <= out_sr << 1;
                    bit_cnt <= bit_cnt + BC_W'(1);
                    if (bit_cnt == BC_W'(WORD_W - 1)) begin
                        bit_cnt  <= '0;
                        word_idx <= word_idx + CNT_W'(1);
                        out_sr   <= snap[next_slot];
                        if (word_idx == n_hit - CNT_W'(1)) phase <= RD_PAR;
                    end
                end
                default: phase <= RD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hit_match_capture.sv
// Top: strip synchroniser and coincidence, tagged ring store, and the
// trigger matcher with serial framing.
// Assumes: all ports in the clk domain except hit_in, which is asynchronous.
module hit_match_capture #(
    parameter int LAYERS     = 4,
    parameter int STRIPS     = 8,
    parameter int TAG_W      = 16,
    parameter int DEPTH_LOG2 = 8,
    parameter int SNAP_DEPTH = 16,
    parameter int CNT_W      = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [LAYERS*STRIPS-1:0]       hit_in,
    input  logic [$clog2(LAYERS+1)-1:0]    majority_cfg,
    input  logic [TAG_W-1:0]               win_cfg,
    input  logic                           mtrig_valid,
    input  logic [TAG_W-1:0]               mtrig_stamp,
    output logic                           ltrig_out,
    output logic                           ser_out,
    output logic                           busy,
    output logic [CNT_W-1:0]               drop_count
);

    localparam int N_CH   = LAYERS * STRIPS;
    localparam int WORD_W = TAG_W + N_CH;

    logic [N_CH-1:0]       pattern;
    logic [DEPTH_LOG2-1:0] rd_idx, wr_ptr_nxt;
    logic [DEPTH_LOG2:0]   fill_nxt;
    logic [WORD_W-1:0]     rd_word;

    hmc_hit_sync #(.LAYERS(LAYERS), .STRIPS(STRIPS)) u_sync (
        .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .majority_cfg(majority_cfg),
        .pattern(pattern), .ltrig(ltrig_out)
    );

    hmc_tag_ring #(.TAG_W(TAG_W), .PAT_W(N_CH), .DEPTH_LOG2(DEPTH_LOG2)) u_ring (
        .clk(clk), .rst_n(rst_n), .pattern(pattern), .rd_idx(rd_idx),
        .rd_word(rd_word), .wr_ptr_nxt(wr_ptr_nxt), .fill_nxt(fill_nxt)
    );

    hmc_match_ser #(
        .TAG_W(TAG_W), .PAT_W(N_CH), .DEPTH_LOG2(DEPTH_LOG2),
        .SNAP_DEPTH(SNAP_DEPTH), .CNT_W(CNT_W)
    ) u_match (
        .clk(clk), .rst_n(rst_n), .mtrig_valid(mtrig_valid), .mtrig_stamp(mtrig_stamp),
        .win_cfg(win_cfg), .wr_ptr_nxt(wr_ptr_nxt), .fill_nxt(fill_nxt),
        .rd_word(rd_word), .rd_idx(rd_idx), .ser_out(ser_out), .busy(busy),
        .drop_count(drop_count)
    );

endmodule

// File: rtl/hit_match_capture_chk.sv
// Port-level temporal checks for hit_match_capture, attached by bind.
// Assumes: hit_in is sampled like a synchronous input in simulation.
module hit_match_capture_chk #(
    parameter int LAYERS = 4,
    parameter int STRIPS = 8,
    parameter int TAG_W  = 16,
    parameter int CNT_W  = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [LAYERS*STRIPS-1:0]     hit_in,
    input logic [$clog2(LAYERS+1)-1:0]  majority_cfg,
    input logic                         mtrig_valid,
    input logic                         ltrig_out,
    input logic                         ser_out,
    input logic                         busy,
    input logic [CNT_W-1:0]             drop_count
);

    function automatic int layers_of(input logic [LAYERS*STRIPS-1:0] v);
        int n = 0;
        for (int l = 0; l < LAYERS; l++) if (|v[l*STRIPS +: STRIPS]) n++;
        return n;
    endfunction

    function automatic int level_of(input int c);
        return (c < 2) ? 2 : ((c > LAYERS) ? LAYERS : c);
    endfunction

    // R2
    ltrig_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ltrig_out |-> (layers_of($past(hit_in, 3)) >= level_of(int'($past(majority_cfg)))));

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mtrig_valid && !busy) |=> busy);

    // R9
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mtrig_valid && busy && (drop_count != '1)) |=> (drop_count == $past(drop_count) + CNT_W'(1)));

    // R9
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mtrig_valid && busy) |=> $stable(drop_count));

    // R7
    line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> !ser_out);

    // R7
    scan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !ser_out);

endmodule

bind hit_match_capture hit_match_capture_chk #(
    .LAYERS(LAYERS), .STRIPS(STRIPS), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .majority_cfg(majority_cfg),
    .mtrig_valid(mtrig_valid), .ltrig_out(ltrig_out), .ser_out(ser_out),
    .busy(busy), .drop_count(drop_count)
);

// File: tb/hit_match_capture_test.sv
`timescale 1ns/1ps
module hit_match_capture_test;

    localparam real CLK_PERIOD = 25.0;
    localparam int  LAYERS = 4, STRIPS = 8, TAG_W = 8, DEPTH_LOG2 = 4, SNAP = 4, CNT_W = 8;
    localparam int  N_CH = LAYERS * STRIPS;
    localparam int  WORD_W = TAG_W + N_CH;
    localparam int  DEPTH = 1 << DEPTH_LOG2;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic [N_CH-1:0]   hit_in = '0;
    logic [2:0]        majority_cfg = 3'd3;
    logic [TAG_W-1:0]  win_cfg = '0, mtrig_stamp = '0;
    logic              mtrig_valid = 1'b0;
    logic              ltrig_out, ser_out, busy;
    logic [CNT_W-1:0]  drop_count;

    int n_chk = 0, n_fail = 0, edge_cnt = 0, mdl_n = 0, exp_n = 0;
    logic [WORD_W-1:0] mdl [0:4095];
    logic [WORD_W-1:0] exp_w [0:SNAP-1];

    hit_match_capture #(.LAYERS(LAYERS), .STRIPS(STRIPS), .TAG_W(TAG_W),
        .DEPTH_LOG2(DEPTH_LOG2), .SNAP_DEPTH(SNAP), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .majority_cfg(majority_cfg),
        .win_cfg(win_cfg), .mtrig_valid(mtrig_valid), .mtrig_stamp(mtrig_stamp),
        .ltrig_out(ltrig_out), .ser_out(ser_out), .busy(busy), .drop_count(drop_count));

    always #(CLK_PERIOD / 2.0) clk = ~clk;
    always @(posedge clk) if (rst_n) edge_cnt <= edge_cnt + 1;

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Present one pattern for one cycle and record the expected stored word (R4)
    task automatic present(input logic [N_CH-1:0] p);
        hit_in = p;
        if (p != '0) begin
            mdl[mdl_n] = {TAG_W'(edge_cnt + 2), p};
            mdl_n++;
        end
        @(negedge clk);
    endtask

    // Compute expected frame contents, then pulse the main trigger (R5, R6, R8)
    task automatic fire(input logic [TAG_W-1:0] st, input logic [TAG_W-1:0] w);
        int lo;
        logic [TAG_W-1:0] t, du, dd;
        repeat (3) @(negedge clk);
        lo = (mdl_n > DEPTH) ? mdl_n - DEPTH : 0;
        exp_n = 0;
        for (int i = lo; i < mdl_n; i++) begin
            t  = mdl[i][WORD_W-1 -: TAG_W];
            du = t - st;
            dd = st - t;
            if ((du <= w || dd <= w) && exp_n < SNAP) begin
                exp_w[exp_n] = mdl[i];
                exp_n++;
            end
        end
        win_cfg = w; mtrig_stamp = st; mtrig_valid = 1'b1;
        @(negedge clk);
        mtrig_valid = 1'b0;
        check(busy === 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
    endtask

    // Capture and compare one frame (R7 plus the caller's requirement)
    task automatic receive(input string req);
        int guard = 0;
        logic [CNT_W-1:0] rc = '0;
        logic [WORD_W-1:0] rw;
        logic pe = 1'b0;
        while (ser_out !== 1'b1 && guard < 3000) begin @(negedge clk); guard++; end
        check(guard < 3000, {req, " R7 start bit"}, 64'(guard), 64'd0);
        for (int i = 0; i < CNT_W; i++) begin @(negedge clk); rc = {rc[CNT_W-2:0], ser_out}; end
        check(rc == CNT_W'(exp_n), {req, " R8 count"}, 64'(rc), 64'(exp_n));
        for (int i = 0; i < CNT_W; i++) pe ^= rc[i];
        for (int k = 0; k < exp_n; k++) begin
            rw = '0;
            for (int b = 0; b < WORD_W; b++) begin @(negedge clk); rw = {rw[WORD_W-2:0], ser_out}; end
            check(rw == exp_w[k], {req, " R4 word"}, 64'(rw), 64'(exp_w[k]));
            for (int b = 0; b < WORD_W; b++) pe ^= exp_w[k][b];
        end
        @(negedge clk);
        check(ser_out == pe, "R7 parity", 64'(ser_out), 64'(pe));
        @(negedge clk);
        check(ser_out == 1'b0 && busy == 1'b0, "R7 R9 line idle after frame",
              64'({busy, ser_out}), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [TAG_W-1:0] t2, ta;
        repeat (3) @(negedge clk);
        check({ltrig_out, ser_out, busy} == 3'b0 && drop_count == '0, "R1 in reset",
              64'({ltrig_out, ser_out, busy, drop_count}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({ltrig_out, ser_out, busy} == 3'b0 && drop_count == '0, "R1 after reset",
              64'({ltrig_out, ser_out, busy, drop_count}), 64'd0);

        // R2 R3: every layer subset against every majority setting
        for (int maj = 0; maj < 8; maj++) begin
            for (int m = 0; m < 16; m++) begin
                logic [N_CH-1:0] p = '0;
                int nl = 0, thr;
                for (int l = 0; l < LAYERS; l++)
                    if (m[l]) begin p[l*STRIPS + (maj + l) % STRIPS] = 1'b1; nl++; end
                thr = (maj < 2) ? 2 : ((maj > 4) ? 4 : maj);
                majority_cfg = 3'(maj);
                present(p);
                hit_in = '0;
                @(negedge clk);
                @(negedge clk);
                check(ltrig_out == (nl >= thr), "R2 R3 coincidence", 64'(ltrig_out), 64'(nl >= thr));
                @(negedge clk);
                check(ltrig_out == 1'b0, "R2 single pulse", 64'(ltrig_out), 64'd0);
            end
        end

        // R4 R5: window sweep around a sparse group of hits
        present(32'h0000_0101); hit_in = '0; repeat (2) @(negedge clk);
        t2 = TAG_W'(edge_cnt + 2);
        present(32'h0202_0000); hit_in = '0; @(negedge clk);
        present(32'h8000_0004); hit_in = '0;
        for (int w = 0; w < 4; w++) begin
            for (int off = -4; off <= 4; off++) begin
                fire(TAG_W'(int'(t2) + off), TAG_W'(w));
                receive("R5 window");
            end
        end

        // R5: tags straddling the counter wrap
        while (TAG_W'(edge_cnt + 2) != '1) @(negedge clk);
        present(32'h1111_0000);
        present(32'h0000_2222);
        hit_in = '0;
        fire('0, TAG_W'(1));   receive("R5 wrap both");
        fire(TAG_W'(254), '0); receive("R5 wrap below");

        // R6 R8: burst longer than the ring
        ta = TAG_W'(edge_cnt + 2);
        for (int i = 0; i < DEPTH + 3; i++) present(32'h0101_0101 * (i + 1));
        hit_in = '0;
        fire(ta + TAG_W'(9), TAG_W'(12));
        check(exp_n == SNAP, "R8 cap reached in model", 64'(exp_n), 64'(SNAP));
        receive("R6 R8 overflow");

        // R10 R9: hits and a trigger landing during a scan
        fire(ta, '0);
        t2 = TAG_W'(edge_cnt + 2);
        present(32'h00F0_0000);
        present(32'h0F00_0000);
        hit_in = '0;
        mtrig_stamp = t2; mtrig_valid = 1'b1;
        @(negedge clk);
        mtrig_valid = 1'b0;
        check(drop_count == CNT_W'(1), "R9 drop counted", 64'(drop_count), 64'd1);
        receive("R10 frozen view");
        check(drop_count == CNT_W'(1), "R9 drop held", 64'(drop_count), 64'd1);
        fire(t2, TAG_W'(1));
        check(exp_n == 2, "R10 late hits in model", 64'(exp_n), 64'd2);
        receive("R10 late hits");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule